// File: doc/BRIEF.md
# Synchronous Parallel FIFO Link Master

This block is the logic-side master of an 8-bit synchronous parallel FIFO link to a USB bridge device. Every register in it runs on the 60 MHz clock that the device supplies. The block watches two active-low flags from the device. One says a received byte is waiting. The other says the device can take a byte to transmit.

Received bytes leave the block on a local valid/ready stream. Bytes to transmit enter it on a second valid/ready stream. The block sequences the output-enable, read and write strobes. It also turns the shared data bus around so that the device and the block never drive it at the same time.

A one-cycle request on the local side produces a single-clock low pulse on the send-immediate line. This makes the device flush a short packet. When both directions have work, the block alternates between read and write bursts. A read burst stops in time to protect a small local receive buffer.

Top module: `sfb_bridge_ctrl`

## Requirements
- R1: While reset is high and right after it, output-enable, read strobe, write strobe and send-immediate are all high (1 = inactive), the data bus is not driven, and the receive stream shows no valid byte.
- R2: A received byte is captured from the bus at every rising edge where both the receive flag and the read strobe are low (0). Bytes leave on the receive stream in the order the device presented them.
- R3: Output-enable is low for at least one cycle before the read strobe falls. The block never drives the data bus while output-enable is low.
- R4: A transmit byte is taken by the device at every rising edge where both the transmit flag and the write strobe are low. If an edge passes with the transmit flag high, the byte on the bus is kept and sent later. No byte is lost or repeated, and order is preserved.
- R5: The block starts driving the bus only after a cycle in which output-enable and the read strobe were both high.
- R6: An edge where the read strobe is low but the receive flag is high moves no byte. Such an edge adds nothing to the receive stream.
- R7: The receive buffer never holds more than RX_DEPTH bytes. The read strobe rises before the buffer would overflow, counting the byte already committed by the registered strobe. A stalled consumer loses no byte.
- R8: When an idle cycle finds both directions possible, the direction not granted last is granted. Under mixed throttling, neither direction starves.
- R9: Each send-immediate request gives exactly one low pulse of one clock. That pulse never overlaps a low write strobe.
- R10: A read burst ends in the cycle after an edge with the receive flag high. A write burst ends after an edge with the transmit flag high or with no further local byte. Once all traffic has drained, all strobes rest high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz clock supplied by the device |
| rst | input | 1 | Synchronous active-high reset |
| bus_d_i | input | DATA_W | Data bus as seen from the device side |
| bus_d_o | output | DATA_W | Byte the block places on the bus |
| bus_d_drive | output | 1 | High while the block drives the bus |
| dev_rx_avail_n | input | 1 | Low: the device holds a byte to read |
| dev_tx_space_n | input | 1 | Low: the device can accept a byte |
| dev_oe_n | output | 1 | Low: the device drives the bus |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dev_flush_n | output | 1 | Send-immediate strobe, active low |
| rx_data | output | DATA_W | Received byte at the head of the buffer |
| rx_valid | output | 1 | Receive stream holds a byte |
| rx_ready | input | 1 | Local consumer takes the byte |
| tx_data | input | DATA_W | Local byte to transmit |
| tx_valid | input | 1 | Local byte is present |
| tx_ready | output | 1 | Block takes the local byte this edge |
| flush_req | input | 1 | One-cycle request for a send-immediate pulse |

## Verification
The bench builds the block with DATA_W = 8 and RX_DEPTH = 2. With a buffer only two deep, the stop-before-full rule and the in-flight byte are hit on nearly every read burst whenever the consumer stalls. The bench sweeps every pairing of four consumer-ready patterns with three device-flag throttling patterns. Each run moves twenty bytes each way and ends in a flush request. Flags that drop in mid-burst, refused write edges and contention between the two directions therefore all occur many times.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_TURN,
        ST_RD,
        ST_WR,
        ST_FLUSH
    } link_state_e;

    typedef enum logic [1:0] {
        GR_NONE,
        GR_FLUSH,
        GR_RD,
        GR_WR
    } grant_e;

    typedef struct packed {
        logic oe_n;
        logic rd_n;
        logic wr_n;
        logic drive;
        logic flush_n;
    } pin_set_t;

    // Strobe levels for each link state; decoded from the state flop only.
    function automatic pin_set_t pins_for(link_state_e s);
        pin_set_t p;
        p.oe_n    = !(s == ST_RD_TURN || s == ST_RD);
        p.rd_n    = (s != ST_RD);
        p.wr_n    = (s != ST_WR);
        p.drive   = (s == ST_WR);
        p.flush_n = (s != ST_FLUSH);
        return p;
    endfunction

endpackage

// File: rtl/sfb_rx_buf.sv
module sfb_rx_buf #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         not_empty,
    output logic         not_full,
    output logic         room_next
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] cnt_q, cnt_next;

    assign cnt_next  = cnt_q + CW'(push) - CW'(pop);
    assign not_empty = (cnt_q != '0);
    assign not_full  = (cnt_q < FULL);
    assign room_next = (cnt_next < FULL);
    assign dout      = mem[rptr_q];

    always_ff @(posedge clk) begin
        if (push) mem[wptr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
            if (pop)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
            cnt_q <= cnt_next;
        end
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt_q < FULL));
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt_q != '0));
    a_r7_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL);

endmodule

// File: rtl/sfb_tx_hold.sv
module sfb_tx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         consume,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            dout <= '0;
        end else begin
            if (load) begin
                dout <= din;
                full <= 1'b1;
            end else if (consume) begin
                full <= 1'b0;
            end
        end
    end

    // R4: a byte is only consumed while one is held
    a_r4_consume_held: assert property (@(posedge clk) disable iff (rst)
        consume |-> full);
    // R4: a held byte stays unchanged until it is consumed or replaced
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (full && !load && !consume) |=> (full && $stable(dout)));

endmodule

// File: rtl/sfb_arbiter.sv
module sfb_arbiter
    import sfb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   idle,
    input  logic   can_rd,
    input  logic   can_wr,
    input  logic   flush_req,
    output grant_e grant
);
    logic last_rd_q;
    logic flush_pend_q;

    always_comb begin
        grant = GR_NONE;
        if (idle) begin
            if (flush_pend_q)          grant = GR_FLUSH;
            else if (can_rd && can_wr) grant = last_rd_q ? GR_WR : GR_RD;
            else if (can_rd)           grant = GR_RD;
            else if (can_wr)           grant = GR_WR;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_rd_q    <= 1'b0;
            flush_pend_q <= 1'b0;
        end else begin
            if (grant == GR_RD) last_rd_q <= 1'b1;
            if (grant == GR_WR) last_rd_q <= 1'b0;
            flush_pend_q <= flush_req || (flush_pend_q && grant != GR_FLUSH);
        end
    end

    // R8: on contention the direction granted last yields
    a_r8_alternate_rd: assert property (@(posedge clk) disable iff (rst)
        (grant == GR_RD && can_wr) |-> !last_rd_q);
    a_r8_alternate_wr: assert property (@(posedge clk) disable iff (rst)
        (grant == GR_WR && can_rd) |-> last_rd_q);
    // R9: a request is remembered until served
    a_r9_req_kept: assert property (@(posedge clk) disable iff (rst)
        flush_req |=> flush_pend_q);

endmodule

// File: rtl/sfb_bridge_ctrl.sv
module sfb_bridge_ctrl
    import sfb_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int RX_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] bus_d_i,
    output logic [DATA_W-1:0] bus_d_o,
    output logic              bus_d_drive,
    input  logic              dev_rx_avail_n,
    input  logic              dev_tx_space_n,
    output logic              dev_oe_n,
    output logic              dev_rd_n,
    output logic              dev_wr_n,
    output logic              dev_flush_n,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              flush_req
);
    link_state_e state_q, state_d;
    pin_set_t    pins;
    grant_e      grant;

    logic rd_xfer, wr_xfer, rx_pop;
    logic rx_not_full, rx_room_next;
    logic hold_full, tx_load;
    logic can_rd, can_wr, idle;

    assign pins        = pins_for(state_q);
    assign dev_oe_n    = pins.oe_n;
    assign dev_rd_n    = pins.rd_n;
    assign dev_wr_n    = pins.wr_n;
    assign dev_flush_n = pins.flush_n;
    assign bus_d_drive = pins.drive;

    // Byte movement on this edge: device flag and local strobe both low
    assign rd_xfer = !pins.rd_n && !dev_rx_avail_n;
    assign wr_xfer = !pins.wr_n && !dev_tx_space_n;
    assign rx_pop  = rx_valid && rx_ready;

    assign idle   = (state_q == ST_IDLE);
    assign can_rd = !dev_rx_avail_n && rx_not_full;
    assign can_wr = !dev_tx_space_n && (hold_full || tx_valid);

    assign tx_load  = (idle && grant == GR_WR && !hold_full)
                   || (state_q == ST_WR && wr_xfer && tx_valid);
    assign tx_ready = tx_load;

    sfb_rx_buf #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rx_buf (
        .clk       (clk),
        .rst       (rst),
        .push      (rd_xfer),
        .din       (bus_d_i),
        .pop       (rx_pop),
        .dout      (rx_data),
        .not_empty (rx_valid),
        .not_full  (rx_not_full),
        .room_next (rx_room_next)
    );

    sfb_tx_hold #(.W(DATA_W)) u_tx_hold (
        .clk     (clk),
        .rst     (rst),
        .load    (tx_load),
        .consume (wr_xfer),
        .din     (tx_data),
        .dout    (bus_d_o),
        .full    (hold_full)
    );

    sfb_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .idle      (idle),
        .can_rd    (can_rd),
        .can_wr    (can_wr),
        .flush_req (flush_req),
        .grant     (grant)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                unique case (grant)
                    GR_FLUSH: state_d = ST_FLUSH;
                    GR_RD:    state_d = ST_RD_TURN;
                    GR_WR:    state_d = ST_WR;
                    default:  state_d = ST_IDLE;
                endcase
            end
            ST_RD_TURN: state_d = can_rd ? ST_RD : ST_IDLE;
            // Stay only if the byte committed by the registered strobe fits
            ST_RD:      state_d = (!dev_rx_avail_n && rx_room_next) ? ST_RD : ST_IDLE;
            ST_WR:      state_d = (wr_xfer && tx_valid) ? ST_WR : ST_IDLE;
            ST_FLUSH:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // R3: output-enable leads the read strobe by at least one cycle
    a_r3_oe_leads_rd: assert property (@(posedge clk) disable iff (rst)
        $fell(dev_rd_n) |-> !$past(dev_oe_n));
    // R3: no contention on the shared bus
    a_r3_no_fight: assert property (@(posedge clk) disable iff (rst)
        !(bus_d_drive && !dev_oe_n));
    // R5: a quiet cycle precedes bus drive
    a_r5_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_d_drive) |-> ($past(dev_oe_n) && $past(dev_rd_n)));
    // R9: single-clock pulse, never during a write strobe
    a_r9_one_clock: assert property (@(posedge clk) disable iff (rst)
        !dev_flush_n |=> dev_flush_n);
    a_r9_not_in_write: assert property (@(posedge clk) disable iff (rst)
        !dev_flush_n |-> dev_wr_n);
    // R4: a write strobe always has a byte behind it
    a_r4_byte_behind_wr: assert property (@(posedge clk) disable iff (rst)
        !dev_wr_n |-> hold_full);
    // R10: bursts end after a refusing edge
    a_r10_rd_stop: assert property (@(posedge clk) disable iff (rst)
        (!dev_rd_n && dev_rx_avail_n) |=> dev_rd_n);
    a_r10_wr_stop: assert property (@(posedge clk) disable iff (rst)
        (!dev_wr_n && dev_tx_space_n) |=> dev_wr_n);

endmodule

// File: tb/sfb_bridge_ctrl_tb.sv
module sfb_bridge_ctrl_tb;
    localparam int CLK_PERIOD = 16;
    localparam int W = 8;
    localparam int DEPTH = 2;
    localparam int N = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] bus_d_i, bus_d_o, rx_data, tx_data;
    logic bus_d_drive, dev_rx_avail_n, dev_tx_space_n;
    logic dev_oe_n, dev_rd_n, dev_wr_n, dev_flush_n;
    logic rx_valid, rx_ready, tx_valid, tx_ready, flush_req;

    int cyc, rmode, tmode;
    int dev_rx_idx, dev_tx_got, rx_got, src_idx, rx_bad, tx_bad;
    int n_chk = 0, n_err = 0;
    int v_fight = 0, v_turn = 0, v_gap = 0, v_fl = 0, fl_cnt;
    logic p_oe, p_rd, p_drv, p_fl;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sfb_bridge_ctrl #(.DATA_W(W), .RX_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .bus_d_i(bus_d_i), .bus_d_o(bus_d_o),
        .bus_d_drive(bus_d_drive), .dev_rx_avail_n(dev_rx_avail_n),
        .dev_tx_space_n(dev_tx_space_n), .dev_oe_n(dev_oe_n),
        .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n), .dev_flush_n(dev_flush_n),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .flush_req(flush_req)
    );

    function automatic logic rx_gate(int c, int m);
        if (m == 1) return (c % 5) != 0;
        if (m == 2) return (c % 9) < 3;
        return 1'b1;
    endfunction
    function automatic logic tx_gate(int c, int m);
        if (m == 1) return (c % 4) != 1;
        if (m == 2) return (c % 11) < 4;
        return 1'b1;
    endfunction
    function automatic logic rdy_gate(int c, int m);
        if (m == 1) return (c % 2) == 1;
        if (m == 2) return (c % 7) < 2;
        if (m == 3) return (c % 16) >= 10;
        return 1'b1;
    endfunction
    function automatic logic [W-1:0] rx_byte(int i);
        return W'(i * 13 + 5);
    endfunction
    function automatic logic [W-1:0] tx_byte(int i);
        return W'(i * 7 + 3);
    endfunction

    // Device and local-side models
    assign dev_rx_avail_n = !(dev_rx_idx < N && rx_gate(cyc, tmode));
    assign dev_tx_space_n = !tx_gate(cyc, tmode);
    assign bus_d_i  = !dev_oe_n ? rx_byte(dev_rx_idx) : '0;
    assign rx_ready = rdy_gate(cyc, rmode);
    assign tx_valid = (src_idx < N) && (((rmode % 2) == 0) || ((cyc % 3) != 0));
    assign tx_data  = tx_byte(src_idx);
    assign flush_req = (cyc == 40);

    always @(posedge clk) begin
        if (rst) begin
            cyc <= 0; dev_rx_idx <= 0; dev_tx_got <= 0; rx_got <= 0;
            src_idx <= 0; rx_bad <= 0; tx_bad <= 0;
        end else begin
            cyc <= cyc + 1;
            if (!dev_rd_n && !dev_rx_avail_n) dev_rx_idx <= dev_rx_idx + 1;
            if (!dev_wr_n && !dev_tx_space_n) begin
                if (!bus_d_drive || bus_d_o != tx_byte(dev_tx_got)) tx_bad <= tx_bad + 1;
                dev_tx_got <= dev_tx_got + 1;
            end
            if (rx_valid && rx_ready) begin
                if (rx_data != rx_byte(rx_got)) rx_bad <= rx_bad + 1;
                rx_got <= rx_got + 1;
            end
            if (tx_valid && tx_ready) src_idx <= src_idx + 1;
        end
    end

    // Protocol monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst) begin
            p_oe = 1'b1; p_rd = 1'b1; p_drv = 1'b0; p_fl = 1'b1; fl_cnt = 0;
        end else begin
            if (bus_d_drive && !dev_oe_n) v_fight++;
            if (!dev_rd_n && p_rd && p_oe) v_turn++;
            if (bus_d_drive && !p_drv && (!p_oe || !p_rd)) v_gap++;
            if (!dev_flush_n && (!p_fl || !dev_wr_n)) v_fl++;
            if (!dev_flush_n && p_fl) fl_cnt++;
            p_oe = dev_oe_n; p_rd = dev_rd_n; p_drv = bus_d_drive; p_fl = dev_flush_n;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run(input int rm, input int tm);
        bit done;
        rmode = rm; tmode = tm;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: idle pins and empty receive stream under reset
        chk({dev_oe_n, dev_rd_n, dev_wr_n, dev_flush_n, bus_d_drive, rx_valid} == 6'b111100,
            "R1", "reset pins", int'({dev_oe_n, dev_rd_n, dev_wr_n, dev_flush_n, bus_d_drive, rx_valid}),
            int'(6'b111100));
        rst = 1'b0;
        done = 1'b0;
        for (int k = 0; k < 4000 && !done; k++) begin
            @(negedge clk);
            done = (rx_got == N) && (dev_tx_got == N) && (cyc >= 50);
        end
        chk(done, "R8", "both directions finished", rx_got + dev_tx_got, 2 * N);
        repeat (6) @(negedge clk);
        chk(rx_got == N, "R7", "received count", rx_got, N);
        chk(rx_bad == 0, "R6", "receive order mismatches", rx_bad, 0);
        chk(dev_tx_got == N, "R4", "transmitted count", dev_tx_got, N);
        chk(tx_bad == 0, "R4", "transmit order mismatches", tx_bad, 0);
        chk({dev_oe_n, dev_rd_n, dev_wr_n} == 3'b111, "R10", "strobes at rest",
            int'({dev_oe_n, dev_rd_n, dev_wr_n}), 7);
        chk(fl_cnt == 1, "R9", "send-immediate pulses", fl_cnt, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int rm = 0; rm < 4; rm++)
            for (int tm = 0; tm < 3; tm++)
                run(rm, tm);
        chk(v_fight == 0, "R3", "bus driven while output-enable low", v_fight, 0);
        chk(v_turn == 0, "R3", "read strobe without output-enable lead", v_turn, 0);
        chk(v_gap == 0, "R5", "drive without quiet cycle", v_gap, 0);
        chk(v_fl == 0, "R9", "bad send-immediate pulse", v_fl, 0);
        // R2: exact count and order above cover capture on flag-and-strobe edges
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule